// File: doc/BRIEF.md
# Instruction Trace Event Profiler

The profiler sits beside a processor's per-instruction trace port and keeps a set of saturating event counters. Each cycle in which the trace port presents a retired instruction, the block tallies the instruction itself. It also tallies any register-file write, taken branch, branch-target-cache hit, delay-slot instruction, data read, data write and taken exception that the instruction reports. Taken exceptions are also sorted by their 5-bit kind code into a bank of per-kind counters. A taken exception whose code is not one of the defined kinds goes to a separate counter that records reserved codes.

Software or a debug agent reads any counter through a small indexed read port, which returns the value one cycle after the index is presented. A synchronous clear input zeroes every counter at once. The counter width and the presence of the branch-target-cache hit counter are parameters. The trace inputs are assumed to come from the core's trace outputs, or from a driver in simulation.

Top module: `trace_event_profiler`

## Requirements
- R1: The retired-instruction counter (index 0) increments once in every cycle in which the valid strobe `tr_valid` is 1, and never when it is 0.
- R2: The register-write (index 1), taken-branch (index 2) and delay-slot (index 4) counters increment only in cycles where both `tr_valid` and the matching flag are 1.
- R3: The data-read counter (index 5) increments when `tr_valid`, `tr_dacc` and `tr_drd` are all 1. The data-write counter (index 6) increments when `tr_valid`, `tr_dacc` and `tr_dwr` are all 1. Neither changes when `tr_dacc` is 0.
- R4: The taken-exception total (index 7) increments when `tr_valid` and `tr_exc_taken` are both 1, whatever the code. When `tr_exc_taken` is 0, `tr_exc_kind` has no effect on any counter.
- R5: A taken exception with a defined kind code increments the per-kind counter at index 32 + code. The defined codes are 0 to 7, 10, 11, 12 and 16 to 19.
- R6: A taken exception with any other code increments the reserved-kind counter (index 8) and no per-kind counter. Per-kind indices of reserved codes always read 0.
- R7: The branch-target-cache hit counter (index 3) counts `tr_valid` & `tr_btc_hit` when `HAS_BTC_HIT` is 1. When `HAS_BTC_HIT` is 0 it always reads 0.
- R8: Every counter saturates at all ones and does not wrap.
- R9: `clr` zeroes all counters at the next clock edge. An increment in the same cycle is discarded.
- R10: `rd_data` shows the counter selected by `rd_idx` one clock edge after the index is presented. Indices 9 to 31 read 0.
- R11: After reset every counter and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tr_valid | input | 1 | Trace carries a retired instruction this cycle |
| tr_reg_wr | input | 1 | Instruction writes the register file |
| tr_br_taken | input | 1 | Branch evaluated taken |
| tr_btc_hit | input | 1 | Branch-target-cache hit |
| tr_delay_slot | input | 1 | Instruction sits in a taken branch's delay slot |
| tr_dacc | input | 1 | Data-side access is valid |
| tr_drd | input | 1 | Data access is a read |
| tr_dwr | input | 1 | Data access is a write |
| tr_exc_taken | input | 1 | Instruction results in a taken exception |
| tr_exc_kind | input | 5 | Exception kind code |
| clr | input | 1 | Synchronous clear of all counters |
| rd_idx | input | 6 | Counter index for the read port |
| rd_data | output | CW | Selected counter value, registered |

## Verification
The clear and an increment can fall in the same cycle. The bench first drives several hundred valid register-writing instructions so the counters sit at saturation. It then asserts `clr` in the same cycle as another valid instruction and expects the retired, register-write and saturated counters to read exactly 0 afterwards rather than 1. A read can also be presented in the same cycle as counting. That case is judged by holding the trace idle while changing the index and checking that `rd_data` keeps the old value until the following edge.

// File: rtl/trace_prof_pkg.sv
package trace_prof_pkg;
   localparam int IDX_W     = 6;
   localparam int KIND_W    = 5;
   localparam int NUM_KIND  = 1 << KIND_W;
   localparam int KIND_BASE = 32;
   localparam int NUM_EV    = 9;

   // bit k set: exception code k is a defined kind
   localparam logic [NUM_KIND-1:0] KIND_DEFINED = 32'h000F_1CFF;

   typedef enum logic [3:0] {
      EV_RETIRED = 4'd0,
      EV_REGWR   = 4'd1,
      EV_BRANCH  = 4'd2,
      EV_BTCHIT  = 4'd3,
      EV_DSLOT   = 4'd4,
      EV_DREAD   = 4'd5,
      EV_DWRITE  = 4'd6,
      EV_EXC     = 4'd7,
      EV_RSVD    = 4'd8
   } ev_e;
endpackage

// File: rtl/prof_sat_counter.sv
module prof_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   initial assert (W >= 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt == '1) |=> cnt == '1); // R8
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0); // R9
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt)); // R1
endmodule

// File: rtl/prof_event_decode.sv
module prof_event_decode
   import trace_prof_pkg::*;
#(
   parameter bit HAS_BTC_HIT = 1'b1
) (
   input  logic                tr_valid,
   input  logic                tr_reg_wr,
   input  logic                tr_br_taken,
   input  logic                tr_btc_hit,
   input  logic                tr_delay_slot,
   input  logic                tr_dacc,
   input  logic                tr_drd,
   input  logic                tr_dwr,
   input  logic                tr_exc_taken,
   input  logic [KIND_W-1:0]   tr_exc_kind,
   output logic [NUM_EV-1:0]   ev_inc,
   output logic [NUM_KIND-1:0] kind_inc
);
   logic exc_ok;
   logic code_known;

   assign exc_ok     = tr_valid & tr_exc_taken;
   assign code_known = KIND_DEFINED[tr_exc_kind];

   always_comb begin
      ev_inc             = '0;
      ev_inc[EV_RETIRED] = tr_valid;
      ev_inc[EV_REGWR]   = tr_valid & tr_reg_wr;
      ev_inc[EV_BRANCH]  = tr_valid & tr_br_taken;
      ev_inc[EV_BTCHIT]  = HAS_BTC_HIT & tr_valid & tr_btc_hit;
      ev_inc[EV_DSLOT]   = tr_valid & tr_delay_slot;
      ev_inc[EV_DREAD]   = tr_valid & tr_dacc & tr_drd;
      ev_inc[EV_DWRITE]  = tr_valid & tr_dacc & tr_dwr;
      ev_inc[EV_EXC]     = exc_ok;
      ev_inc[EV_RSVD]    = exc_ok & ~code_known;
   end

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
      assign kind_inc[k] = exc_ok & KIND_DEFINED[k] & (tr_exc_kind == KIND_W'(k));
   end
endmodule

// File: rtl/prof_read_mux.sv
module prof_read_mux
   import trace_prof_pkg::*;
#(
   parameter int CW = 32
) (
   input  logic [IDX_W-1:0]             idx,
   input  logic [NUM_EV-1:0][CW-1:0]    ev_cnt,
   input  logic [NUM_KIND-1:0][CW-1:0]  kind_cnt,
   output logic [CW-1:0]                sel
);
   always_comb begin
      sel = '0;
      if (idx >= IDX_W'(KIND_BASE))
         sel = kind_cnt[idx[KIND_W-1:0]];
      else if (idx < IDX_W'(NUM_EV))
         sel = ev_cnt[idx[3:0]];
   end
endmodule

// File: rtl/trace_event_profiler.sv
module trace_event_profiler
   import trace_prof_pkg::*;
#(
   parameter int CW          = 32,
   parameter bit HAS_BTC_HIT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tr_valid,
   input  logic          tr_reg_wr,
   input  logic          tr_br_taken,
   input  logic          tr_btc_hit,
   input  logic          tr_delay_slot,
   input  logic          tr_dacc,
   input  logic          tr_drd,
   input  logic          tr_dwr,
   input  logic          tr_exc_taken,
   input  logic [4:0]    tr_exc_kind,
   input  logic          clr,
   input  logic [5:0]    rd_idx,
   output logic [CW-1:0] rd_data
);
   initial assert (CW >= 2 && CW <= 64);
   initial assert (KIND_BASE + NUM_KIND <= (1 << IDX_W));

   logic [NUM_EV-1:0]           ev_inc;
   logic [NUM_KIND-1:0]         kind_inc;
   logic [NUM_EV-1:0][CW-1:0]   ev_cnt;
   logic [NUM_KIND-1:0][CW-1:0] kind_cnt;
   logic [CW-1:0]               rd_next;

   prof_event_decode #(.HAS_BTC_HIT(HAS_BTC_HIT)) u_dec (
      .tr_valid, .tr_reg_wr, .tr_br_taken, .tr_btc_hit, .tr_delay_slot,
      .tr_dacc, .tr_drd, .tr_dwr, .tr_exc_taken, .tr_exc_kind,
      .ev_inc, .kind_inc
   );

   for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
      if (i == int'(EV_BTCHIT) && !HAS_BTC_HIT) begin : g_off
         assign ev_cnt[i] = '0;
      end else begin : g_on
         prof_sat_counter #(.W(CW)) u_cnt (
            .clk, .rst_n, .clr, .inc(ev_inc[i]), .cnt(ev_cnt[i])
         );
      end
   end

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_kcnt
      if (KIND_DEFINED[k]) begin : g_def
         prof_sat_counter #(.W(CW)) u_cnt (
            .clk, .rst_n, .clr, .inc(kind_inc[k]), .cnt(kind_cnt[k])
         );
      end else begin : g_rsv
         assign kind_cnt[k] = '0;
      end
   end

   prof_read_mux #(.CW(CW)) u_mux (
      .idx(rd_idx), .ev_cnt, .kind_cnt, .sel(rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_next;
   end

   AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_inc[EV_RSVD], kind_inc})); // R6
   AST_NO_KIND_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      !tr_exc_taken |-> kind_inc == '0); // R4
   AST_RETIRED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tr_valid && !clr) |=> $stable(ev_cnt[EV_RETIRED])); // R1
   AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tr_dacc && !clr) |=> ($stable(ev_cnt[EV_DREAD]) && $stable(ev_cnt[EV_DWRITE]))); // R3

   if (!HAS_BTC_HIT) begin : g_btc_chk
      AST_BTC_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
         rd_idx == 6'd3 |=> rd_data == '0); // R7
   end
endmodule

// File: tb/sim_trace_event_profiler.sv
`timescale 1ns/1ps
module sim_trace_event_profiler;
   localparam int CW = 8;
   localparam logic [31:0] DEF = 32'h000F_1CFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tr_valid = 0, tr_reg_wr = 0, tr_br_taken = 0, tr_btc_hit = 0;
   logic tr_delay_slot = 0, tr_dacc = 0, tr_drd = 0, tr_dwr = 0, tr_exc_taken = 0;
   logic [4:0] tr_exc_kind = '0;
   logic clr = 0;
   logic [5:0] rd_idx = '0;
   logic [CW-1:0] rd_data, rd_data1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   trace_event_profiler #(.CW(CW), .HAS_BTC_HIT(1'b1)) u0 (
      .clk, .rst_n, .tr_valid, .tr_reg_wr, .tr_br_taken, .tr_btc_hit,
      .tr_delay_slot, .tr_dacc, .tr_drd, .tr_dwr, .tr_exc_taken, .tr_exc_kind,
      .clr, .rd_idx, .rd_data(rd_data)
   );

   trace_event_profiler #(.CW(CW), .HAS_BTC_HIT(1'b0)) u1 (
      .clk, .rst_n, .tr_valid, .tr_reg_wr, .tr_br_taken, .tr_btc_hit,
      .tr_delay_slot, .tr_dacc, .tr_drd, .tr_dwr, .tr_exc_taken, .tr_exc_kind,
      .clr, .rd_idx, .rd_data(rd_data1)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      tr_valid = 0; tr_reg_wr = 0; tr_br_taken = 0; tr_btc_hit = 0;
      tr_delay_slot = 0; tr_dacc = 0; tr_drd = 0; tr_dwr = 0;
      tr_exc_taken = 0; tr_exc_kind = '0; clr = 0;
   endtask

   // present index at negedge, sample one edge later away from the edge
   task automatic rd(input int idx, output int v0, output int v1);
      @(negedge clk); idle(); rd_idx = 6'(idx);
      @(posedge clk); #1;
      v0 = int'(rd_data); v1 = int'(rd_data1);
   endtask

   task automatic do_clear();
      @(negedge clk); idle(); clr = 1;
      @(negedge clk); clr = 0;
   endtask

   initial begin
      int a, b;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R11 reset state
      rd(0, a, b); chk("R11 retired after reset", a, 0);
      rd(8, a, b); chk("R11 reserved after reset", a, 0);

      // sweep all 256 flag combinations
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         {tr_valid, tr_reg_wr, tr_br_taken, tr_btc_hit,
          tr_delay_slot, tr_dacc, tr_drd, tr_dwr} = 8'(v);
      end
      rd(0, a, b); chk("R1 retired", a, 128);
      rd(1, a, b); chk("R2 regwr", a, 64);
      rd(2, a, b); chk("R2 branch", a, 64);
      rd(3, a, b); chk("R7 btc hit enabled", a, 64);
                   chk("R7 btc hit disabled", b, 0);
      rd(4, a, b); chk("R2 delay slot", a, 64);
      rd(5, a, b); chk("R3 data reads", a, 32);
      rd(6, a, b); chk("R3 data writes", a, 32);
      rd(7, a, b); chk("R4 exc total untouched", a, 0);
      rd(20, a, b); chk("R10 unmapped index", a, 0);

      // R10 latency: index change visible only after the next edge
      rd(0, a, b);
      @(negedge clk); rd_idx = 6'd5; #1;
      chk("R10 old value before edge", int'(rd_data), 128);
      @(posedge clk); #1;
      chk("R10 new value after edge", int'(rd_data), 32);

      do_clear();
      // exception sweep over every kind code
      for (int k = 0; k < 32; k++) begin
         @(negedge clk); idle(); tr_valid = 1; tr_exc_taken = 1; tr_exc_kind = 5'(k);
         @(negedge clk); idle(); tr_valid = 1; tr_exc_taken = 0; tr_exc_kind = 5'(k);
         @(negedge clk); idle(); tr_valid = 0; tr_exc_taken = 1; tr_exc_kind = 5'(k);
      end
      rd(7, a, b); chk("R4 exc total", a, 32);
      rd(8, a, b); chk("R6 reserved count", a, 32 - $countones(DEF));
      rd(0, a, b); chk("R1 retired in exc sweep", a, 64);
      for (int k = 0; k < 32; k++) begin
         rd(32 + k, a, b);
         if (DEF[k]) chk($sformatf("R5 kind %0d", k), a, 1);
         else        chk($sformatf("R6 reserved kind slot %0d", k), a, 0);
      end

      // R8 saturation
      do_clear();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk); idle(); tr_valid = 1; tr_reg_wr = 1;
      end
      rd(0, a, b); chk("R8 retired saturates", a, (1 << CW) - 1);
      rd(1, a, b); chk("R8 regwr saturates", a, (1 << CW) - 1);

      // R9 clear colliding with increment
      @(negedge clk); idle(); clr = 1; tr_valid = 1; tr_reg_wr = 1;
      rd(0, a, b); chk("R9 retired clear wins", a, 0);
      rd(1, a, b); chk("R9 regwr clear wins", a, 0);
      rd(7, a, b); chk("R9 exc total cleared", a, 0);

      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule